// File: doc/BRIEF.md
# Straw Hit Timestamp Packer

This block serves a group of sixteen discriminated straw channels. Each channel delivers edge events: a strobe, a polarity flag (rising or falling) and a 4-bit phase code. The phase code says which of sixteen evenly spaced sub-phases of the 40 MHz crossing clock saw the edge, which gives a fine bin of about 1.5 ns. The block keeps a free-running crossing counter that advances once per clock. An external strobe can clear it, and otherwise it wraps around.

Every edge is stamped with the current crossing count and held in a one-entry slot for its channel. When several channels have an occupied slot, a fixed-priority arbiter moves one of them per clock into a derandomizing FIFO, starting with the lowest channel index. A reader drains the FIFO through a show-ahead port: the oldest word is always presented. Edges that cannot be held are discarded. In that case a sticky overflow flag is raised, and the next word from the affected channel carries a marker bit.

Top module: `straw_tdc_packer`

## Requirements
- R1: Each output word is 40 bits. Bit 39 is the loss marker, bits 38:9 the crossing count, bits 8:5 the phase code, bit 4 the polarity (1 = rising, 0 = falling) and bits 3:0 the channel index.
- R2: An edge on channel i is stamped with the crossing count held in the cycle its strobe is sampled. It also takes the phase code and polarity of channel i from that same cycle.
- R3: The crossing counter is 0 after reset and rises by one every clock. It wraps to zero modulo 2^CNT_W.
- R4: When the clear strobe is sampled, the counter holds 0 in the next cycle. An edge sampled in that next cycle is stamped 0.
- R5: Words enter the FIFO at most one per clock. Among occupied slots, the lowest channel index goes first. An isolated edge becomes readable two clocks after its strobe is sampled.
- R6: out_valid is high exactly when the FIFO holds a word. out_word then shows the oldest word, and pop removes it. A pop while the FIFO is empty has no effect.
- R7: While the FIFO holds DEPTH words, newly arriving edges are discarded and overflow is set. Overflow then stays high until reset, and no discarded edge ever appears at the output.
- R8: An edge on a channel whose slot is occupied and not granted in that cycle is discarded, and overflow is set.
- R9: After a discard on channel i, the next word captured from channel i has bit 39 set. Later words from that channel have it clear again.
- R10: After reset, out_valid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_strobe | input | NCH | Edge event per channel, one cycle |
| hit_rise | input | NCH | Edge polarity per channel, 1 = rising |
| hit_phase | input | NCH*FINE_W | Phase code per channel, channel i at bits i*FINE_W upward |
| bc_clear | input | 1 | Crossing counter clear strobe |
| pop | input | 1 | Remove the presented word |
| out_word | output | 40 (derived) | Oldest buffered hit word |
| out_valid | output | 1 | FIFO not empty |
| overflow | output | 1 | Sticky flag set when any edge is discarded |

## Verification
The hardest states to reach are the two loss paths. One is a slot that is still waiting for the arbiter when its channel fires again. The other is a FIFO that is already full when a new burst arrives. To reach the first, the bench fires all sixteen channels together and then re-fires channel 15 one cycle later, before its turn comes. To reach the second, it fires a full burst with reads held off and then fires another. It follows each case by draining the FIFO and checking that the marker bit appears once on the next word of the affected channel and that no discarded edge appears at the output. A second, narrow-counter instance runs beside the main one and sees the counter wrap many times.

// File: rtl/straw_tdc_packer.sv
module straw_tdc_packer #(
  parameter int NCH    = 16,
  parameter int CNT_W  = 30,
  parameter int FINE_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCH-1:0]                 hit_strobe,
  input  logic [NCH-1:0]                 hit_rise,
  input  logic [NCH*FINE_W-1:0]          hit_phase,
  input  logic                           bc_clear,
  input  logic                           pop,
  output logic [CNT_W+FINE_W+$clog2(NCH)+1:0] out_word,
  output logic                           out_valid,
  output logic                           overflow
);
  localparam int ID_W   = $clog2(NCH);
  localparam int WORD_W = CNT_W + FINE_W + ID_W + 2;
  localparam int AW     = $clog2(DEPTH);

  logic [CNT_W-1:0]  bx;
  logic [NCH-1:0]    pend, lost, capt, drop, gnt_1h;
  logic [WORD_W-1:0] slot [NCH];
  logic [WORD_W-1:0] mem  [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       used;
  logic [ID_W-1:0]   gid;
  logic              full, gnt_v, take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bx <= '0;
    else        bx <= bc_clear ? '0 : bx + CNT_W'(1);

  always_comb begin
    gid = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) gid = ID_W'(i);
  end

  assign full   = (used == (AW+1)'(DEPTH));
  assign take   = pop && (used != '0);
  assign gnt_v  = (|pend) && !full;
  assign gnt_1h = gnt_v ? ({{(NCH-1){1'b0}}, 1'b1} << gid) : '0;
  assign capt   = hit_strobe & {NCH{!full}} & (~pend | gnt_1h);
  assign drop   = hit_strobe & ~capt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= '0;
      lost     <= '0;
      overflow <= 1'b0;
    end else begin
      pend     <= (pend & ~gnt_1h) | capt;
      lost     <= (lost & ~capt) | drop;
      overflow <= overflow | (|drop);
    end

  always_ff @(posedge clk)
    for (int i = 0; i < NCH; i++)
      if (capt[i])
        slot[i] <= {lost[i], bx, hit_phase[i*FINE_W +: FINE_W], hit_rise[i], ID_W'(i)};

  always_ff @(posedge clk)
    if (gnt_v) mem[wp] <= slot[gid];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (gnt_v) wp <= wp + AW'(1);
      if (take)  rp <= rp + AW'(1);
      used <= used + (AW+1)'(gnt_v) - (AW+1)'(take);
    end

  assign out_word  = mem[rp];
  assign out_valid = (used != '0);

  AST_BX_STEP:    assert property (@(posedge clk) disable iff (!rst_n) !bc_clear |=> bx == $past(bx) + CNT_W'(1)); // R3
  AST_BX_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n) bc_clear |=> bx == '0); // R4
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n) used <= (AW+1)'(DEPTH)); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!out_valid && !(|pend)) |=> !out_valid); // R6
  AST_FULL_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (full && !pop) |=> used == $past(used)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R7
  AST_DROP_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) (|(hit_strobe & pend & ~gnt_1h)) |=> overflow); // R8
endmodule

// File: tb/straw_tdc_packer_test.sv
module straw_tdc_packer_test;
  localparam int N = 16, D = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] stb = '0, rise = '0;
  logic [N*4-1:0] ph = '0;
  logic bcc = 1'b0, pop = 1'b0, done = 1'b0;
  wire [39:0] w;  wire v, ovf;
  wire [17:0] ws; wire vs, ovfs;

  straw_tdc_packer uut (.clk(clk), .rst_n(rst_n), .hit_strobe(stb), .hit_rise(rise),
    .hit_phase(ph), .bc_clear(bcc), .pop(pop), .out_word(w), .out_valid(v), .overflow(ovf));
  straw_tdc_packer #(.CNT_W(8)) uut_small (.clk(clk), .rst_n(rst_n), .hit_strobe(stb),
    .hit_rise(rise), .hit_phase(ph), .bc_clear(bcc), .pop(pop), .out_word(ws),
    .out_valid(vs), .overflow(ovfs));

  int total = 0, bad = 0;
  logic [29:0] m_cnt;
  bit          m_pv [N];
  bit          m_lost [N];
  logic [39:0] m_pw [N];
  logic [39:0] m_q [$];
  bit          m_ovf;

  always @(posedge clk) begin
    bit full; int g;
    if (!rst_n) begin
      m_cnt = 0; m_ovf = 0; m_q.delete();
      for (int i = 0; i < N; i++) begin m_pv[i] = 0; m_lost[i] = 0; end
    end else begin
      full = (m_q.size() == D); g = -1;
      if (!full) for (int i = N - 1; i >= 0; i--) if (m_pv[i]) g = i;
      if (pop && m_q.size() > 0) void'(m_q.pop_front());
      if (g >= 0) begin m_q.push_back(m_pw[g]); m_pv[g] = 0; end
      for (int i = 0; i < N; i++)
        if (stb[i]) begin
          if (full || m_pv[i]) begin m_lost[i] = 1; m_ovf = 1; end
          else begin
            m_pw[i] = {m_lost[i], m_cnt, ph[i*4 +: 4], rise[i], 4'(i)};
            m_pv[i] = 1; m_lost[i] = 0;
          end
        end
      m_cnt = bcc ? 30'd0 : m_cnt + 30'd1;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(v == (m_q.size() > 0), "R6 valid", 64'(v), 64'(m_q.size() > 0));
    chk(ovf == m_ovf, "R7 overflow", 64'(ovf), 64'(m_ovf));
    if (m_q.size() > 0) begin
      chk(w == m_q[0], "R2 word", 64'(w), 64'(m_q[0]));
      chk(ws == {m_q[0][39], m_q[0][16:9], m_q[0][8:0]}, "R3 narrow counter word",
          64'(ws), 64'({m_q[0][39], m_q[0][16:9], m_q[0][8:0]}));
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic drain(); pop = 1'b1; cyc(20); pop = 1'b0; endtask
  task automatic fire(logic [N-1:0] m);
    stb = m; cyc(1); stb = '0;
  endtask
  task automatic do_reset();
    rst_n = 1'b0; cyc(3);
    chk(v == 1'b0, "R10 valid after reset", 64'(v), 0);
    chk(ovf == 1'b0, "R10 overflow after reset", 64'(ovf), 0);
    rst_n = 1'b1; cyc(1);
  endtask
  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    logic [29:0] e;
    cyc(1);
    do_reset();

    // R1 R2 R5: single rising edge on channel 5, phase 9
    e = m_cnt; ph[20 +: 4] = 4'd9; rise[5] = 1'b1;
    fire(16'h0020); cyc(1);
    chk(v == 1'b1, "R5 two-clock latency", 64'(v), 1);
    chk(w[3:0] == 4'd5, "R1 channel field", 64'(w[3:0]), 5);
    chk(w[8:5] == 4'd9, "R1 phase field", 64'(w[8:5]), 9);
    chk(w[4] == 1'b1, "R1 polarity field", 64'(w[4]), 1);
    chk(w[39] == 1'b0, "R1 marker field", 64'(w[39]), 0);
    chk(w[38:9] == e, "R2 stamp", 64'(w[38:9]), 64'(e));
    drain();

    // R6: pops on empty FIFO are ignored
    pop = 1'b1; cyc(3);
    chk(v == 1'b0, "R6 empty pop", 64'(v), 0);
    pop = 1'b0;

    // R4: clear then falling edge on channel 2
    bcc = 1'b1; cyc(1); bcc = 1'b0; rise = '0;
    fire(16'h0004); cyc(1);
    chk(w[38:9] == 30'd0, "R4 stamp after clear", 64'(w[38:9]), 0);
    chk(w[3:0] == 4'd2 && w[4] == 1'b0, "R4 word id/polarity", 64'(w[4:0]), 2);
    drain();

    // R5: all channels together, ascending order
    for (int i = 0; i < N; i++) ph[i*4 +: 4] = 4'(15 - i);
    fire('1); cyc(20);
    for (int k = 0; k < N; k++) begin
      chk(w[3:0] == 4'(k), "R5 priority order", 64'(w[3:0]), 64'(k));
      pop = 1'b1; cyc(1); pop = 1'b0;
    end
    chk(v == 1'b0, "R5 burst count", 64'(v), 0);

    // random traffic, counter wraps in the narrow instance (R3)
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++) stb[i] = ($urandom_range(99) < 4);
      rise = N'($urandom); ph = {$urandom, $urandom};
      pop = ($urandom_range(99) < 70);
      bcc = ($urandom_range(999) < 3);
      cyc(1);
    end
    stb = '0; bcc = 1'b0; drain();
    do_reset();

    // R8 R9: channel 15 re-fires while its slot waits
    fire('1); fire(16'h8000);
    chk(ovf == 1'b1, "R8 busy slot discard", 64'(ovf), 1);
    cyc(20); drain();
    chk(v == 1'b0, "R8 only burst words", 64'(v), 0);
    fire(16'h8000); cyc(1);
    chk(w[39] == 1'b1 && w[3:0] == 4'd15, "R9 marker set", 64'({w[39], w[3:0]}), 64'h1f);
    drain();
    fire(16'h8000); cyc(1);
    chk(w[39] == 1'b0, "R9 marker cleared", 64'(w[39]), 0);
    drain();
    do_reset();

    // R7: full FIFO discards a second burst
    fire('1); cyc(20);
    chk(ovf == 1'b0, "R7 no loss at exact fill", 64'(ovf), 0);
    fire('1); cyc(20);
    chk(ovf == 1'b1, "R7 overflow set", 64'(ovf), 1);
    pop = 1'b1; cyc(D); pop = 1'b0;
    chk(v == 1'b0, "R7 discarded words absent", 64'(v), 0);
    cyc(5);
    chk(ovf == 1'b1, "R7 overflow sticky", 64'(ovf), 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule